// File: doc/BRIEF.md
# Linear Array Readout Sequencer

This block is the digital control core of a line-scan photodiode array. The array is read out one pixel at a time. A single start pulse on the serial start input places a token in a chain of shift-register sections, and each section covers a fixed number of pixels. As the token advances on every rising clock edge, it selects each pixel in turn, in ascending order, for connection to the output. It pulses that pixel's integrator reset when the token moves on. It also enables the section's output driver while one of that section's pixels is selected.

Each section's carry output feeds the start input of the next section. With the default two sections of 64 pixels, a frame spans 128 pixels. The carry of the last section marks end of data and can start a further device.

A guard in front of the first section keeps a second token out of the chain. It rejects a start that is held high for more than one edge, or that arrives while a frame is still in progress. Either case raises a sticky error flag. Analog integration and the output voltage levels are not modelled. Output-enable stands in for the tri-state driver.

Top module: `linear_readout_seq`

## Requirements
- R1: With no frame in progress and start low at the previous edge, a rising edge that samples `start_i` high starts a frame: pixel 1 (bit 0 of `pix_sel_o`) is selected after that edge.
- R2: After the k-th edge of a frame (k = 1..128), `pix_sel_o` is one-hot with only bit k-1 set, so pixels are selected in ascending order and the frame crosses from section 1 (bits 0..63) into section 2 (bits 64..127) without a gap.
- R3: When a pixel's select bit falls, its bit of `pix_rst_o` is high for exactly one cycle. For pixel k this is the cycle after edge k+1, and no other reset bit is high in that cycle.
- R4: `out_en_o[s]` is high exactly while a pixel of section s is selected, and low whenever no pixel is selected.
- R5: `carry_o[s]` is high during the cycle in which the last pixel of section s is selected. `carry_o[0]` (after edge 64) is the start input of section 2. `carry_o[1]` (after edge 128) is the end-of-data marker.
- R6: Edge 129 empties the chain, so `pix_sel_o`, `out_en_o` and `carry_o` are all zero. A start sampled at edge 130 begins a new frame at once.
- R7: If `start_i` is sampled high on two consecutive edges, the second sample injects no token and sets `start_err_o`. The flag stays high until reset.
- R8: A start sampled while any pixel is selected is ignored (the single token keeps its position) and sets `start_err_o`. This includes edge 129.
- R9: A synchronous reset clears all select bits, pixel resets, output enables, carries and the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Serial start for the first section |
| pix_sel_o | output | 128 | One-hot pixel select, bit 0 = pixel 1 |
| pix_rst_o | output | 128 | Per-pixel integrator reset strobe |
| out_en_o | output | 2 | Per-section output enable |
| carry_o | output | 2 | Per-section serial carry out |
| start_err_o | output | 1 | Sticky start-protocol error flag |

## Verification
Every output is a register or a direct decode of one, so each result appears one edge after the edge that sampled its cause. After frame edge k, the select bit for pixel k, the enable and carry of the owning section, and the reset strobe for pixel k-1 are all due. The bench drives and samples on falling edges. It counts edges from the one that samples the start, and it sweeps every edge of a frame, 1 through 129, comparing the full 128-bit buses against values built from k. It also places rejected starts at the exact edges named in R7 and R8 (a consecutive high, edge 50, and edge 129), checks the flag and the token position on the following falling edge, and checks that a start at edge 130 yields pixel 1 at once.

// File: rtl/readout_seq_pkg.sv
package readout_seq_pkg;

    typedef struct packed {
        logic prev;
        logic err;
    } guard_st_t;

endpackage

// File: rtl/readout_start_guard.sv
module readout_start_guard
    import readout_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic busy_i,
    output logic tok_o,
    output logic err_o
);

    guard_st_t st_d, st_q;
    logic      accept;

    always_comb begin
        accept    = start_i & ~st_q.prev & ~busy_i;
        st_d      = st_q;
        st_d.prev = start_i;
        st_d.err  = st_q.err | (start_i & (st_q.prev | busy_i));
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tok_o = accept & ~rst;
    assign err_o = st_q.err;

endmodule

// File: rtl/readout_section.sv
module readout_section #(
    parameter int PIX = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tok_i,
    output logic [PIX-1:0] sel_o,
    output logic [PIX-1:0] prst_o,
    output logic           oe_o,
    output logic           carry_o
);

    typedef struct packed {
        logic [PIX-1:0] sel;
        logic [PIX-1:0] prst;
    } sec_st_t;

    sec_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sel  = {st_q.sel[PIX-2:0], tok_i};
        st_d.prst = st_q.sel & ~st_d.sel;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sel_o   = st_q.sel;
    assign prst_o  = st_q.prst;
    assign oe_o    = |st_q.sel;
    assign carry_o = st_q.sel[PIX-1];

endmodule

// File: rtl/linear_readout_seq.sv
module linear_readout_seq #(
    parameter int PIX_PER_SEC = 64,
    parameter int NUM_SEC     = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start_i,
    output logic [PIX_PER_SEC*NUM_SEC-1:0] pix_sel_o,
    output logic [PIX_PER_SEC*NUM_SEC-1:0] pix_rst_o,
    output logic [NUM_SEC-1:0]             out_en_o,
    output logic [NUM_SEC-1:0]             carry_o,
    output logic                           start_err_o
);

    localparam int TOT = PIX_PER_SEC * NUM_SEC;

    logic [NUM_SEC:0] chain;
    logic             busy;

    assign busy = |pix_sel_o;

    readout_start_guard u_guard (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .busy_i  (busy),
        .tok_o   (chain[0]),
        .err_o   (start_err_o)
    );

    for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
        readout_section #(.PIX(PIX_PER_SEC)) u_sec (
            .clk     (clk),
            .rst     (rst),
            .tok_i   (chain[s]),
            .sel_o   (pix_sel_o[s*PIX_PER_SEC +: PIX_PER_SEC]),
            .prst_o  (pix_rst_o[s*PIX_PER_SEC +: PIX_PER_SEC]),
            .oe_o    (out_en_o[s]),
            .carry_o (chain[s+1])
        );
    end

    assign carry_o = chain[NUM_SEC:1];

endmodule

// File: rtl/readout_seq_checks.sv
module readout_seq_checks #(
    parameter int PIX  = 64,
    parameter int NSEC = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                start_i,
    input logic [PIX*NSEC-1:0] pix_sel_o,
    input logic [PIX*NSEC-1:0] pix_rst_o,
    input logic [NSEC-1:0]     out_en_o,
    input logic [NSEC-1:0]     carry_o,
    input logic                start_err_o
);

    a_r1_accept: assert property (@(posedge clk) disable iff (rst)
        (start_i && !$past(start_i) && pix_sel_o == '0) |=> pix_sel_o[0]);

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pix_sel_o));

    a_r3_single: assert property (@(posedge clk) disable iff (rst)
        $countones(pix_rst_o) <= 1);

    a_r3_first: assert property (@(posedge clk) disable iff (rst)
        $fell(pix_sel_o[0]) |-> pix_rst_o[0]);

    a_r4_idle_oe: assert property (@(posedge clk) disable iff (rst)
        (pix_sel_o == '0) |-> (out_en_o == '0));

    a_r6_close: assert property (@(posedge clk) disable iff (rst)
        carry_o[NSEC-1] |=> (pix_sel_o == '0));

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        start_err_o |=> start_err_o);

    a_r9_clear: assert property (@(posedge clk)
        rst |=> (pix_sel_o == '0 && out_en_o == '0 && !start_err_o));

endmodule

bind linear_readout_seq readout_seq_checks #(.PIX(PIX_PER_SEC), .NSEC(NUM_SEC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .pix_sel_o   (pix_sel_o),
    .pix_rst_o   (pix_rst_o),
    .out_en_o    (out_en_o),
    .carry_o     (carry_o),
    .start_err_o (start_err_o)
);

// File: tb/linear_readout_seq_test.sv
module linear_readout_seq_test;

    localparam int PIX = 64;
    localparam int NS  = 2;
    localparam int TOT = PIX * NS;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start_i = 1'b0;
    logic [TOT-1:0] pix_sel_o, pix_rst_o;
    logic [NS-1:0]  out_en_o, carry_o;
    logic           start_err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    localparam logic [TOT-1:0] ONE = 1;

    linear_readout_seq #(.PIX_PER_SEC(PIX), .NUM_SEC(NS)) uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .pix_sel_o(pix_sel_o), .pix_rst_o(pix_rst_o),
        .out_en_o(out_en_o), .carry_o(carry_o), .start_err_o(start_err_o)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, logic [TOT-1:0] act, logic [TOT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_edges(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_edges(2);
        rst = 1'b0;
    endtask

    // Expected values after frame edge k (k=1 is the edge sampling start).
    task automatic check_edge(int k);
        logic [TOT-1:0] es, ep;
        logic [NS-1:0]  eo, ec;
        es = (k >= 1 && k <= TOT) ? (ONE << (k-1)) : '0;
        ep = (k >= 2 && k <= TOT+1) ? (ONE << (k-2)) : '0;
        eo = {(k > PIX && k <= TOT), (k >= 1 && k <= PIX)};
        ec = {(k == TOT), (k == PIX)};
        chk($sformatf("R2 sel k=%0d", k), pix_sel_o, es);
        chk($sformatf("R3 prst k=%0d", k), pix_rst_o, ep);
        chk($sformatf("R4 oe k=%0d", k), TOT'(out_en_o), TOT'(eo));
        chk($sformatf("R5 carry k=%0d", k), TOT'(carry_o), TOT'(ec));
    endtask

    // Begins at a falling edge; start is sampled at the next rising edge.
    task automatic run_frame();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 first pixel", pix_sel_o, ONE);
        for (int k = 1; k <= TOT + 1; k++) begin
            if (k > 1) @(negedge clk);
            check_edge(k);
        end
        // R6: chain empty after edge 129
        chk("R6 empty after close", pix_sel_o, '0);
    endtask

    initial begin
        do_reset();
        // R9 reset state
        chk("R9 reset sel", pix_sel_o, '0);
        chk("R9 reset prst", pix_rst_o, '0);
        chk("R9 reset oe", TOT'(out_en_o), '0);
        chk("R9 reset err", TOT'(start_err_o), '0);

        run_frame();
        // R6: back-to-back, start sampled at edge 130
        run_frame();
        chk("R6 no error on edge-130 start", TOT'(start_err_o), '0);

        // R8: start at edge 129 rejected
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_edges(127);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 edge-129 start ignored", pix_sel_o, '0);
        chk("R8 edge-129 error", TOT'(start_err_o), 1);
        wait_edges(2);
        chk("R8 no late token", pix_sel_o, '0);
        chk("R7 error sticky", TOT'(start_err_o), 1);

        // R8: start at edge 50 of a frame rejected
        do_reset();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_edges(48);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 mid-frame token kept", pix_sel_o, ONE << 49);
        chk("R8 mid-frame error", TOT'(start_err_o), 1);
        wait_edges(3);
        chk("R8 single token later", pix_sel_o, ONE << 52);

        // R9: reset clears error and frame
        do_reset();
        chk("R9 err cleared", TOT'(start_err_o), 0);
        chk("R9 sel cleared", pix_sel_o, '0);

        // R7: start held high on two edges
        start_i = 1'b1;
        @(negedge clk);
        chk("R7 first edge accepted", pix_sel_o, ONE);
        chk("R7 no error yet", TOT'(start_err_o), 0);
        @(negedge clk);
        start_i = 1'b0;
        chk("R7 second edge no token", pix_sel_o, ONE << 1);
        chk("R7 error raised", TOT'(start_err_o), 1);
        wait_edges(3);
        chk("R7 token alone", pix_sel_o, ONE << 4);

        // R9: reset in the middle of a frame
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 mid sel", pix_sel_o, '0);
        chk("R9 mid prst", pix_rst_o, '0);
        chk("R9 mid oe", TOT'(out_en_o), '0);
        chk("R9 mid carry", TOT'(carry_o), '0);
        chk("R9 mid err", TOT'(start_err_o), '0);

        run_frame();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule